// File: doc/BRIEF.md
# Serial Frame Alignment Synchronizer

This block sits behind a line decoder and receives one data bit per cycle in which `bit_en` is high. It hunts for a fixed alignment word that repeats once per frame. Once the word is confirmed, it marks each bit with its frame position. `sof` pulses on the first bit of every frame. `den` marks payload bits, and `oof` reports whether the frame is currently locked.

A free-running frame position counter drives `sof` and `den` at all times. While the block is hunting, that counter keeps the last known alignment. When a new lock forms at a different place in the bit stream, the counter jumps to that place and a sticky flag, `cofa`, records the move. A strobe clears the flag.

Frame length, word width, word value and the lock and loss frame counts are all parameters. The defaults are a 1536-bit frame and a 10-bit word `1111010000`.

Top module: `fas_sync`

## Requirements
- R1: After reset, `oof` is 1 and `cofa` is 0. `sof` still pulses on the first enabled bit after reset and on every FRAME_LEN-th enabled bit after it, whatever the data.
- R2: The alignment word is PATTERN (default `1111010000`). It is received leftmost bit first and occupies frame bit positions 0 to PAT_W-1.
- R3: The word must be seen at the same offset in LOCK_CNT (default 3) consecutive frames. Then `oof` falls, and from the next frame `sof` and `den` line up with that offset.
- R4: A frame without the word at the candidate offset during confirmation sends the block back to the search. A fresh run of LOCK_CNT good frames is then needed.
- R5: While locked, LOSS_CNT (default 4) consecutive frames without the word at the locked offset raise `oof`. A single frame that has the word resets the miss count.
- R6: While `oof` is 1, `sof` and `den` keep following the last locked frame position.
- R7: `den` is 0 on frame positions 0 to PAT_W-1 and 1 on all later positions. `sof` is 1 only on position 0.
- R8: A cycle with `bit_en` low drives `sof` and `den` to 0 and does not change the frame position or the status.
- R9: `cofa` becomes 1 when a lock forms at an offset that differs from the previous lock. It stays 0 on the first lock after reset. It holds until `cofa_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Decoded serial receive bit |
| cofa_clr | input | 1 | Clears the change-of-alignment flag |
| oof | output | 1 | Out-of-frame level |
| sof | output | 1 | Start-of-frame pulse, aligned to `rx_bit` |
| den | output | 1 | Payload-bit marker, aligned to `rx_bit` |
| cofa | output | 1 | Sticky change-of-alignment flag |

## Verification
The hardest case to reach is a relock at a new offset. The old lock must first fail for LOSS_CNT frames, and the new word must then be confirmed LOCK_CNT times.

The bench gets there by inserting a few extra zero bits into a locked stream. Valid frames then land at a shifted offset. Each one is a miss for the old alignment and, once the block is hunting, a hit for the new candidate.

Interleaving a bad frame into a confirmation run covers the search restart. Gaps in `bit_en` in the middle of a frame show that the alignment does not drift.

// File: rtl/fas_pkg.sv
package fas_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCK    = 2'd2
    } fas_state_e;
endpackage

// File: rtl/fas_window.sv
// Sliding window over the last PAT_W bits, compared with the alignment word.
module fas_window #(
    parameter int              PAT_W   = 10,
    parameter logic [PAT_W-1:0] PATTERN = 10'b1111010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din,
    output logic match
);
    logic [PAT_W-1:0] win_d, win_q;

    always_comb begin
        win_d = {win_q[PAT_W-2:0], din};
        // match is qualified by the bit arriving in this cycle
        match = shift_en && (win_d == PATTERN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (shift_en)
            win_q <= win_d;
    end
endmodule

// File: rtl/fas_mod_counter.sv
// Modulo counter holding the frame position of the next enabled bit.
module fas_mod_counter #(
    parameter int MOD = 1536,
    parameter int CW  = $clog2(MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(MOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (adv)
            cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/fas_ctrl.sv
// Hunt / confirm / lock sequencing, loss counting and alignment-change flag.
module fas_ctrl
    import fas_pkg::*;
#(
    parameter int FRAME_LEN = 1536,
    parameter int PAT_W     = 10,
    parameter int LOCK_CNT  = 3,
    parameter int LOSS_CNT  = 4,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          match,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] cand,
    input  logic          cofa_clr,
    output logic          pos_load,
    output logic          cand_load,
    output logic          oof,
    output logic          cofa
);
    localparam int HW = $clog2(LOCK_CNT + 1);
    localparam int MW = $clog2(LOSS_CNT + 1);
    localparam logic [CW-1:0] LAST_OVH = CW'(PAT_W - 1);
    localparam logic [HW:0]   LOCK_LIM = (HW + 1)'(LOCK_CNT);
    localparam logic [MW:0]   LOSS_LIM = (MW + 1)'(LOSS_CNT);

    typedef struct packed {
        fas_state_e    state;
        logic [HW-1:0] hits;
        logic [MW-1:0] misses;
        logic          oof;
        logic          cofa;
        logic          seen_lock;
    } ctrl_t;

    ctrl_t         r_d, r_q;
    logic          lock_now;
    logic [HW:0]   hits_inc;
    logic [MW:0]   miss_inc;

    always_comb begin
        r_d       = r_q;
        pos_load  = 1'b0;
        cand_load = 1'b0;
        lock_now  = 1'b0;
        hits_inc  = {1'b0, r_q.hits} + 1'b1;
        miss_inc  = {1'b0, r_q.misses} + 1'b1;

        if (cofa_clr)
            r_d.cofa = 1'b0;

        if (bit_en) begin
            unique case (r_q.state)
                ST_HUNT: begin
                    if (match) begin
                        if (LOCK_CNT <= 1) begin
                            lock_now = 1'b1;
                        end else begin
                            r_d.state = ST_CONFIRM;
                            r_d.hits  = HW'(1);
                            cand_load = 1'b1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (cand == LAST_OVH) begin
                        if (match) begin
                            if (hits_inc >= LOCK_LIM)
                                lock_now = 1'b1;
                            else
                                r_d.hits = hits_inc[HW-1:0];
                        end else begin
                            r_d.state = ST_HUNT;
                            r_d.hits  = '0;
                        end
                    end
                end
                ST_LOCK: begin
                    if (pos == LAST_OVH) begin
                        if (match) begin
                            r_d.misses = '0;
                        end else if (miss_inc >= LOSS_LIM) begin
                            r_d.state  = ST_HUNT;
                            r_d.oof    = 1'b1;
                            r_d.misses = '0;
                        end else begin
                            r_d.misses = miss_inc[MW-1:0];
                        end
                    end
                end
                default: r_d.state = ST_HUNT;
            endcase
        end

        if (lock_now) begin
            r_d.state     = ST_LOCK;
            r_d.oof       = 1'b0;
            r_d.hits      = '0;
            r_d.misses    = '0;
            pos_load      = 1'b1;
            r_d.seen_lock = 1'b1;
            if (r_q.seen_lock && (pos != LAST_OVH))
                r_d.cofa = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_HUNT;
            r_q.hits      <= '0;
            r_q.misses    <= '0;
            r_q.oof       <= 1'b1;
            r_q.cofa      <= 1'b0;
            r_q.seen_lock <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign oof  = r_q.oof;
    assign cofa = r_q.cofa;
endmodule

// File: rtl/fas_sync.sv
module fas_sync #(
    parameter int               FRAME_LEN = 1536,
    parameter int               PAT_W     = 10,
    parameter logic [PAT_W-1:0] PATTERN   = 10'b1111010000,
    parameter int               LOCK_CNT  = 3,
    parameter int               LOSS_CNT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic cofa_clr,
    output logic oof,
    output logic sof,
    output logic den,
    output logic cofa
);
    localparam int            CW        = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] AFTER_OVH = CW'(PAT_W);

    logic          match;
    logic          pos_load, cand_load;
    logic [CW-1:0] pos, cand;

    fas_window #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_window (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_en), .din(rx_bit), .match(match)
    );

    // position of the next bit under the live alignment
    fas_mod_counter #(.MOD(FRAME_LEN), .CW(CW)) u_pos (
        .clk(clk), .rst_n(rst_n), .adv(bit_en), .load(pos_load),
        .load_val(AFTER_OVH), .count(pos)
    );

    // position of the next bit under the candidate being confirmed
    fas_mod_counter #(.MOD(FRAME_LEN), .CW(CW)) u_cand (
        .clk(clk), .rst_n(rst_n), .adv(bit_en), .load(cand_load),
        .load_val(AFTER_OVH), .count(cand)
    );

    fas_ctrl #(
        .FRAME_LEN(FRAME_LEN), .PAT_W(PAT_W), .LOCK_CNT(LOCK_CNT),
        .LOSS_CNT(LOSS_CNT), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .match(match),
        .pos(pos), .cand(cand), .cofa_clr(cofa_clr),
        .pos_load(pos_load), .cand_load(cand_load), .oof(oof), .cofa(cofa)
    );

    always_comb begin
        sof = bit_en && (pos == '0);
        den = bit_en && (pos >= AFTER_OVH);
    end
endmodule

// File: rtl/fas_sync_chk.sv
module fas_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic cofa_clr,
    input logic oof,
    input logic sof,
    input logic den,
    input logic cofa
);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> (!sof && !den));

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !cofa_clr) |=> ($stable(oof) && $stable(cofa)));

    assert_sof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    assert_sof_overhead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> !den);

    assert_cofa_at_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cofa) |-> $fell(oof));

    assert_cofa_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cofa && !cofa_clr) |=> cofa);

    assert_lock_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> $past(bit_en));
endmodule

bind fas_sync fas_sync_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cofa_clr(cofa_clr),
    .oof(oof), .sof(sof), .den(den), .cofa(cofa)
);

// File: tb/fas_sync_bench.sv
module fas_sync_bench;
    localparam int             FL  = 32;
    localparam int             PW  = 10;
    localparam logic [PW-1:0]  PAT = 10'b1111010000;
    // {frame carries word, expected oof at last bit of that frame}
    localparam logic [1:0] VEC [0:18] = '{
        2'b11, 2'b11, 2'b01, 2'b11, 2'b11, 2'b10,
        2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00,
        2'b01, 2'b01, 2'b11, 2'b11, 2'b10
    };

    logic clk, rst_n, bit_en, rx_bit, cofa_clr;
    logic oof, sof, den, cofa;
    logic s_sof, s_den, s_oof, s_cofa;
    int   checks, errors;
    bit   done;

    fas_sync #(.FRAME_LEN(FL), .PAT_W(PW), .PATTERN(PAT)) u_fas_sync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .cofa_clr(cofa_clr), .oof(oof), .sof(sof), .den(den), .cofa(cofa)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic en, input logic clr);
        @(negedge clk);
        rx_bit = b; bit_en = en; cofa_clr = clr;
        #2;
        s_sof = sof; s_den = den; s_oof = oof; s_cofa = cofa;
    endtask

    // one frame; align: check sof/den per bit; gap_at: 3 idle cycles before that bit;
    // sof_pos: if >= 0, expect sof exactly at that bit
    task automatic send_frame(input logic good, input logic align, input int gap_at,
                              input int sof_pos);
        int bad = 0;
        int gap_bad = 0;
        int sbad = 0;
        for (int i = 0; i < FL; i++) begin
            if (i == gap_at) begin
                for (int g = 0; g < 3; g++) begin
                    send_bit(1'b1, 1'b0, 1'b0);
                    if (s_sof || s_den) gap_bad++;
                end
            end
            send_bit((good && i < PW) ? PAT[PW-1-i] : 1'b0, 1'b1, 1'b0);
            if (align && ((s_sof != (i == 0)) || (s_den != (i >= PW)))) bad++;
            if (sof_pos >= 0 && (s_sof != (i == sof_pos))) sbad++;
        end
        if (align)       check("R6/R7 alignment mismatches", bad, 0);
        if (gap_at >= 0) check("R8 sof/den during idle", gap_bad, 0);
        if (sof_pos >= 0) check("R1 free-running sof period", sbad, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; done = 0;
        rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; cofa_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sof at first enabled bit, lead-in of 5 zero bits
        send_bit(1'b0, 1'b1, 1'b0);
        check("R1 oof after reset", s_oof, 1);
        check("R1 cofa after reset", s_cofa, 0);
        check("R1 sof on first bit", s_sof, 1);
        for (int i = 1; i < 5; i++) begin
            send_bit(1'b0, 1'b1, 1'b0);
            check("R1 no sof in lead-in", s_sof, 0);
        end

        // table: confirm restart (R4), lock (R2/R3), miss reset and loss (R5), hunt (R6)
        for (int k = 0; k < 19; k++) begin
            send_frame(VEC[k][1], k >= 6, -1, (k == 0) ? 27 : -1);
            check(k < 6 ? "R3/R4 oof" : "R5 oof", s_oof, int'(VEC[k][0]));
        end
        check("R9 no flag on first lock or same-offset relock", s_cofa, 0);

        // R9: shift stream by 7 bits, relock at new offset
        for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b1, 1'b0);
        for (int f = 1; f <= 6; f++) begin
            send_frame(1'b1, 1'b0, -1, -1);
            if (f == 3) check("R5 still locked after 3 misses", s_oof, 0);
            if (f == 4) check("R5 loss after 4 misses", s_oof, 1);
            if (f == 5) check("R9 flag clear before relock", s_cofa, 0);
            if (f == 6) begin
                check("R3 relock at new offset", s_oof, 0);
                check("R9 flag set on moved lock", s_cofa, 1);
            end
        end
        send_frame(1'b1, 1'b1, -1, -1);
        check("R9 flag sticky", s_cofa, 1);
        send_bit(1'b0, 1'b0, 1'b1);
        send_bit(1'b0, 1'b0, 1'b0);
        check("R9 flag cleared by strobe", s_cofa, 0);

        // R8: idle cycles mid-frame keep alignment
        send_frame(1'b1, 1'b1, 15, -1);
        check("R8 oof unchanged across idle", s_oof, 0);
        send_frame(1'b1, 1'b1, -1, -1);
        check("R8 cofa unchanged across idle", s_cofa, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule